// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block drives the digital half of an 8-bit successive-approximation converter. A one-cycle start request starts a binary search. The block presents a trial code to an external DAC and comparator pair, one weighted bit at a time, from the most significant bit down to the least. After each trial it reads back a single comparator verdict. If the verdict says the weighted trial sum is above the input, the bit is dropped; otherwise the bit is kept.

When the lowest bit has been decided, the block delivers a coded byte and flags completion for one cycle. The byte stays on the output until a later conversion replaces it.

Two mode inputs are latched at the moment a conversion is accepted:
- The offset selection is forwarded to the analog side as an offset-injection enable and held there.
- The coding selection chooses between the raw code and a copy of it with the top bit inverted. The raw code reads as straight binary in unipolar use and as offset binary in bipolar use. The inverted-top-bit copy gives two's complement.

Once accepted, a conversion always runs to completion. Further start requests are ignored while it runs.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, busy_o, done_o, offset_en_o, trial_o and result_o are all zero.
- R2: A start_i seen high at a clock edge while busy_o is low is accepted. From the next cycle busy_o is high and trial_o equals 8'h80, with only the top bit set.
- R3: Bits are tried strictly from bit 7 down to bit 0. Each bit holds its trial for SET_CYC cycles and then one sample cycle, so busy_o stays high for exactly 8*(SET_CYC+1) cycles.
- R4: While bit k is on trial, trial_o has bit k set, bits below k clear, and bits above k equal to the decisions already taken.
- R5: A comparator value of 1 in the sample cycle of bit k clears bit k; a value of 0 keeps it. With a comparator that reports trial_o greater than a target T, the raw final code equals T.
- R6: start_i is ignored while busy_o is high. It neither restarts nor disturbs the running search.
- R7: bipolar_i and twos_i are captured only when a start is accepted, and changes during a conversion have no effect. offset_en_o shows the captured bipolar_i value from the cycle after acceptance until the next accepted start.
- R8: With twos_i = 0 captured, result_o equals the raw code. With twos_i = 1 captured, result_o equals the raw code with bit 7 inverted. This holds for both values of bipolar_i.
- R9: done_o is high for exactly one cycle, in the cycle after the bit-0 sample, with busy_o low. result_o changes only in that cycle and otherwise holds its value.
- R10: A start_i held high in the cycle where done_o is high is accepted at the next edge, so a held start_i gives back-to-back conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request |
| bipolar_i | input | 1 | Offset-injection selection, captured at start |
| twos_i | input | 1 | Output coding selection (1 = invert top bit), captured at start |
| cmp_hi_i | input | 1 | Comparator verdict: 1 when the trial sum exceeds the input |
| trial_o | output | 8 | Trial code presented to the DAC (zero when idle) |
| offset_en_o | output | 1 | Captured offset-injection enable |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Coded result, held between completions |

## Verification
Targets at the extremes (0 and 255) show that every bit is either cleared or kept across the whole search, with no stuck decision. Targets at 127 and 128 sit on either side of the top-bit boundary, where both codings flip. Patterns with alternating bits such as 8'hA5 and 8'h5A, plus several pseudo-random targets, show that each bit is decided independently and in the right slot. Each target is run under all four mode combinations, with the mode inputs and start_i toggled in the middle of a conversion and with start_i held high across completions; this separates values captured at start from values read live, and ignored requests from accepted ones.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SET    = 2'd1,
        PH_SAMPLE = 2'd2
    } sar_phase_t;

endpackage

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl
    import sar_pkg::*;
#(
    parameter int W       = 8,
    parameter int SET_CYC = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_hi_i,
    output logic         busy_o,
    output logic         accept_o,
    output logic         finish_o,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] code_o
);

    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
    localparam int CNT_W = (SET_CYC > 1) ? $clog2(SET_CYC) : 1;
    localparam logic [W-1:0]     TOP_ONLY = {1'b1, {(W-1){1'b0}}};
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(W - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SET_CYC - 1);

    typedef struct packed {
        sar_phase_t       phase;
        logic [W-1:0]     trial;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } ctrl_state_t;

    ctrl_state_t st_q, st_d;
    logic [W-1:0] bit_mask;
    logic [W-1:0] decided;

    always_comb begin
        bit_mask = W'(1) << st_q.idx;
        decided  = cmp_hi_i ? (st_q.trial & ~bit_mask) : st_q.trial;
        accept_o = (st_q.phase == PH_IDLE) && start_i;
        finish_o = (st_q.phase == PH_SAMPLE) && (st_q.idx == '0);
        code_o   = decided;
        st_d     = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_SET;
                    st_d.trial = TOP_ONLY;
                    st_d.idx   = TOP_IDX;
                    st_d.cnt   = '0;
                end
            end
            PH_SET: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.phase = PH_SAMPLE;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_SAMPLE: begin
                if (st_q.idx == '0) begin
                    st_d.phase = PH_IDLE;
                    st_d.trial = '0;
                end else begin
                    st_d.phase = PH_SET;
                    st_d.trial = decided | (bit_mask >> 1);
                    st_d.idx   = st_q.idx - IDX_W'(1);
                    st_d.cnt   = '0;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.trial = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, trial: '0, idx: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.phase != PH_IDLE);
    assign trial_o = st_q.trial;

    AST_START_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (trial_o == TOP_ONLY)); // R2

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !finish_o) |=> (busy_o && (trial_o != TOP_ONLY || $past(trial_o) == TOP_ONLY))); // R6

    AST_IDLE_TRIAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_o) |=> (trial_o == '0)); // R4

endmodule

// File: rtl/sar_out_coder.sv
module sar_out_coder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept_i,
    input  logic         bipolar_i,
    input  logic         twos_i,
    input  logic         finish_i,
    input  logic [W-1:0] code_i,
    output logic         offset_en_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);

    localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic         bip;
        logic         twos;
        logic         done;
        logic [W-1:0] result;
    } coder_state_t;

    coder_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = finish_i;
        if (accept_i) begin
            st_d.bip  = bipolar_i;
            st_d.twos = twos_i;
        end
        if (finish_i) begin
            st_d.result = st_q.twos ? (code_i ^ TOP_ONLY) : code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign offset_en_o = st_q.bip;
    assign done_o      = st_q.done;
    assign result_o    = st_q.result;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !finish_i |=> $stable(result_o)); // R9

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(offset_en_o)); // R7

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int W       = 8,
    parameter int SET_CYC = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         bipolar_i,
    input  logic         twos_i,
    input  logic         cmp_hi_i,
    output logic [W-1:0] trial_o,
    output logic         offset_en_o,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);

    logic         accept;
    logic         finish;
    logic [W-1:0] code;

    sar_step_ctrl #(
        .W       (W),
        .SET_CYC (SET_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cmp_hi_i (cmp_hi_i),
        .busy_o   (busy_o),
        .accept_o (accept),
        .finish_o (finish),
        .trial_o  (trial_o),
        .code_o   (code)
    );

    sar_out_coder #(
        .W (W)
    ) u_coder (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .bipolar_i   (bipolar_i),
        .twos_i      (twos_i),
        .finish_i    (finish),
        .code_i      (code),
        .offset_en_o (offset_en_o),
        .done_o      (done_o),
        .result_o    (result_o)
    );

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R3

    AST_DONE_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !done_o || $past(done_o)); // R10

endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb_top;

    localparam int W     = 8;
    localparam int STEP  = 2;
    localparam int CONV  = W * STEP;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         bipolar_i = 1'b0;
    logic         twos_i = 1'b0;
    logic         cmp_hi_i;
    logic [W-1:0] trial_o;
    logic         offset_en_o;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] result_o;
    logic [W-1:0] target = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign cmp_hi_i = (trial_o > target);

    sar_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .bipolar_i   (bipolar_i),
        .twos_i      (twos_i),
        .cmp_hi_i    (cmp_hi_i),
        .trial_o     (trial_o),
        .offset_en_o (offset_en_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (result_o)
    );

    // Behavioural reference: cycle count since acceptance, captured values.
    int          m_cyc = 0;
    logic        m_done = 1'b0;
    logic        m_bip = 1'b0;
    logic        m_twos = 1'b0;
    int          m_tgt = 0;
    int          m_res = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cyc  <= 0;
            m_done <= 1'b0;
            m_bip  <= 1'b0;
            m_twos <= 1'b0;
            m_tgt  <= 0;
            m_res  <= 0;
        end else begin
            m_done <= 1'b0;
            if (m_cyc == CONV) begin
                m_cyc  <= 0;
                m_done <= 1'b1;
                m_res  <= m_twos ? (m_tgt ^ 128) : m_tgt;
            end else if (m_cyc > 0) begin
                m_cyc <= m_cyc + 1;
            end else if (start_i) begin
                m_cyc  <= 1;
                m_tgt  <= int'(target);
                m_bip  <= bipolar_i;
                m_twos <= twos_i;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    function automatic int exp_trial(input int cyc, input int tgt);
        int k;
        int upper;
        if (cyc == 0) return 0;
        k = W - 1 - (cyc - 1) / STEP;
        upper = (255 << (k + 1)) & 255;
        return (tgt & upper) | (1 << k);
    endfunction

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            chk("R3", "busy_o", int'(busy_o), int'(m_cyc > 0));
            chk("R9", "done_o", int'(done_o), int'(m_done));
            chk("R8", "result_o", int'(result_o), m_res);
            chk("R7", "offset_en_o", int'(offset_en_o), int'(m_bip));
            chk("R4", "trial_o", int'(trial_o), exp_trial(m_cyc, m_tgt));
            if (m_cyc == 1) begin
                chk("R2", "first trial", int'(trial_o), 128);
            end
            if (m_done) begin
                chk("R5", "raw code", int'(result_o) ^ (m_twos ? 128 : 0), m_tgt);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic run_one(input int tgt, input logic bip, input logic tw);
        @(negedge clk);
        target    = W'(tgt);
        bipolar_i = bip;
        twos_i    = tw;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        bipolar_i = ~bip;          // R7: must not affect this conversion
        twos_i    = ~tw;
        repeat (5) @(negedge clk);
        start_i   = 1'b1;          // R6: ignored while busy
        @(negedge clk);
        start_i   = 1'b0;
        while (!done_o) @(negedge clk);
        chk("R9", "done pulse seen", int'(done_o), 1);
        repeat (3) @(negedge clk);
        chk("R9", "result holds", int'(result_o), tw ? (tgt ^ 128) : tgt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy_o), 0);
        chk("R1", "result in reset", int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "trial after reset", int'(trial_o), 0);
        chk("R1", "done after reset", int'(done_o), 0);
        chk("R1", "offset after reset", int'(offset_en_o), 0);

        begin
            int pats[8] = '{0, 255, 128, 127, 165, 90, 1, 254};
            foreach (pats[i]) begin
                for (int m = 0; m < 4; m++) begin
                    run_one(pats[i], m[0], m[1]);
                end
            end
        end
        begin
            int lfsr = 8'h3B;
            for (int n = 0; n < 12; n++) begin
                lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 255;
                run_one(lfsr, n[0], n[1]);
            end
        end

        // R10: held start gives back-to-back conversions
        @(negedge clk);
        target    = 8'd77;
        bipolar_i = 1'b1;
        twos_i    = 1'b1;
        start_i   = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            while (!done_o) @(negedge clk);
            @(negedge clk);
            chk("R10", "restart after done", int'(busy_o), 1);
        end
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule